// File: doc/BRIEF.md
# Per-page ECC error report collector

This block sits behind a BCH decoder and condenses the outcome of one page read into a 16-bit report word. The decoder hands it one record per packet: a packet index, a corrected-error count and a decode-success bit. Packet 0 keeps a report byte of its own. Every later packet folds into a second byte, which holds the largest count seen and a success flag that clears as soon as any of those packets fails. The block also watches the data bytes of the page and raises a page-empty (erased) flag when every byte seen was all ones.

A page-start strobe opens a fresh accumulation. A page-end strobe moves the accumulated values into the registers that software reads. Reads go through a small register port with one cycle of latency. Because the readable copy changes only on page end, a read taken while a page is in progress always returns the last finished page.

Top module: `ecc_page_report`

## Requirements
- R1: After reset the report register reads 0x0000_8080 and the status register reads 0x0000_0000.
- R2: Report bits 5:0 hold the error count of the packet with index 0, and bit 7 holds its success flag (1 = decoded, 0 = failed). Bit 6 reads 0.
- R3: Report bits 13:8 hold the maximum error count over all packets with a nonzero index, not the sum of those counts. Bit 14 reads 0.
- R4: Report bit 15 is 1 only if every packet with a nonzero index in the page decoded; one failure makes it 0.
- R5: An error count above 63 is saturated to 63 before it is stored or compared.
- R6: The page-start strobe resets the accumulation so that both counts are 0 and both success flags are 1. A page with no records therefore reports 0x8080.
- R7: The readable report and status change only on the page-end strobe. A read taken during a page, or in the same cycle as page end, returns the previous page's values.
- R8: Status bit 16 is 1 after a page in which at least one data byte was observed and every observed byte was 0xFF. Otherwise it is 0, and all other status bits read 0.
- R9: The report is read at address 0x1C0 and the status at address 0x2C. rd_data is registered: it takes the addressed value one cycle after rd_en, holds while rd_en is low, and reads 0 for any other address.
- R10: A packet record or data byte presented in the same cycle as page start counts toward the new page. One presented in the same cycle as page end is included in the values that page end commits.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_start | input | 1 | Opens a new page accumulation |
| page_end | input | 1 | Commits the accumulation to the readable registers |
| pkt_valid | input | 1 | A packet record is present |
| pkt_idx | input | IDX_W | Packet index within the page |
| pkt_err_cnt | input | CNT_IN_W | Corrected-error count of the packet |
| pkt_ok | input | 1 | 1 when the packet decoded |
| byte_valid | input | 1 | A data byte is present for empty detection |
| byte_data | input | DATA_W | Observed data byte |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | RD_W | Registered read data |

## Verification
A register read can fall in the same cycle as the page-end commit, and a packet record can fall in the same cycle as either strobe. The bench provokes both cases. It raises rd_en together with page_end and expects the old report, then expects the new report from the next read. It also places records on the cycles of page_start and page_end, and the committed word must contain them. Reads taken in the middle of a page must return the previous page's word.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
   localparam int RPT_CNT_W = 6;

   typedef struct packed {
      logic                 ok;
      logic                 rsvd;
      logic [RPT_CNT_W-1:0] cnt;
   } rpt_byte_t;

   typedef struct packed {
      rpt_byte_t rest;
      rpt_byte_t first;
   } rpt_word_t;

   localparam rpt_byte_t RPT_BYTE_CLR = '{ok: 1'b1, rsvd: 1'b0, cnt: '0};
   localparam rpt_word_t RPT_WORD_CLR = '{rest: RPT_BYTE_CLR, first: RPT_BYTE_CLR};
endpackage

// File: rtl/ecc_cnt_sat.sv
module ecc_cnt_sat #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 6
) (
   input  logic [IN_W-1:0]  cnt_in,
   output logic [OUT_W-1:0] cnt_out
);
   if (IN_W < 1 || OUT_W < 1) begin : g_bad_w
      $error("ecc_cnt_sat: widths must be positive");
   end

   if (IN_W > OUT_W) begin : g_sat
      assign cnt_out = (|cnt_in[IN_W-1:OUT_W]) ? {OUT_W{1'b1}} : cnt_in[OUT_W-1:0];
   end else begin : g_ext
      assign cnt_out = OUT_W'(cnt_in);
   end
endmodule

// File: rtl/ecc_pkt_accum.sv
module ecc_pkt_accum
   import ecc_rpt_pkg::*;
#(
   parameter int CNT_IN_W = 8,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                page_start,
   input  logic                pkt_valid,
   input  logic [IDX_W-1:0]    pkt_idx,
   input  logic [CNT_IN_W-1:0] pkt_err_cnt,
   input  logic                pkt_ok,
   output rpt_word_t           acc_next
);
   logic [RPT_CNT_W-1:0] sat_cnt;
   rpt_word_t            acc_q;
   logic                 is_first;

   ecc_cnt_sat #(.IN_W(CNT_IN_W), .OUT_W(RPT_CNT_W)) u_sat (
      .cnt_in (pkt_err_cnt),
      .cnt_out(sat_cnt)
   );

   assign is_first = (pkt_idx == '0);

   always_comb begin
      acc_next = page_start ? RPT_WORD_CLR : acc_q;
      if (pkt_valid) begin
         if (is_first) begin
            acc_next.first.cnt = sat_cnt;
            acc_next.first.ok  = pkt_ok;
         end else begin
            if (sat_cnt > acc_next.rest.cnt) begin
               acc_next.rest.cnt = sat_cnt;
            end
            acc_next.rest.ok = acc_next.rest.ok & pkt_ok;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= RPT_WORD_CLR;
      end else begin
         acc_q <= acc_next;
      end
   end

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (page_start && !pkt_valid) |=> (acc_q == RPT_WORD_CLR));

   assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_idx != '0 && !pkt_ok) |=> !acc_q.rest.ok);

   assert_sat_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_idx == '0 && int'(pkt_err_cnt) > 63) |=> (acc_q.first.cnt == 6'd63));

   assert_max_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_idx != '0 && !page_start) |=> (acc_q.rest.cnt >= $past(acc_q.rest.cnt)));
endmodule

// File: rtl/ecc_empty_detect.sv
module ecc_empty_detect #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_start,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   output logic              empty_next
);
   logic seen_q, all_ff_q;
   logic seen_d, all_ff_d;

   always_comb begin
      seen_d   = page_start ? 1'b0 : seen_q;
      all_ff_d = page_start ? 1'b1 : all_ff_q;
      if (byte_valid) begin
         seen_d   = 1'b1;
         all_ff_d = all_ff_d & (&byte_data);
      end
   end

   assign empty_next = seen_d & all_ff_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q   <= 1'b0;
         all_ff_q <= 1'b1;
      end else begin
         seen_q   <= seen_d;
         all_ff_q <= all_ff_d;
      end
   end

   assert_nonff_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !(&byte_data)) |=> !all_ff_q);

   assert_start_unseen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (page_start && !byte_valid) |=> !seen_q);
endmodule

// File: rtl/ecc_rpt_regs.sv
module ecc_rpt_regs
   import ecc_rpt_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          RD_W        = 32,
   parameter logic [11:0] REPORT_ADDR = 12'h1C0,
   parameter logic [11:0] STATUS_ADDR = 12'h02C,
   parameter int          EMPTY_BIT   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_end,
   input  rpt_word_t         rpt_next,
   input  logic              empty_next,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [RD_W-1:0]   rd_data
);
   localparam int RPT_W = $bits(rpt_word_t);

   if (RD_W < RPT_W || EMPTY_BIT >= RD_W) begin : g_bad_rd
      $error("ecc_rpt_regs: read width too small for report or status bit");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ecc_rpt_regs: address width too small for register map");
   end

   rpt_word_t       report_q;
   logic            empty_q;
   logic [RD_W-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         report_q <= RPT_WORD_CLR;
         empty_q  <= 1'b0;
      end else if (page_end) begin
         report_q <= rpt_next;
         empty_q  <= empty_next;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (rd_addr == ADDR_W'(REPORT_ADDR)) begin
         rd_mux = RD_W'(report_q);
      end else if (rd_addr == ADDR_W'(STATUS_ADDR)) begin
         rd_mux[EMPTY_BIT] = empty_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= rd_mux;
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !page_end |=> ($stable(report_q) && $stable(empty_q)));

   assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      page_end |=> (report_q == $past(rpt_next)));

   assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr != ADDR_W'(REPORT_ADDR) && rd_addr != ADDR_W'(STATUS_ADDR))
      |=> (rd_data == '0));

   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/ecc_page_report.sv
module ecc_page_report
   import ecc_rpt_pkg::*;
#(
   parameter int          CNT_IN_W    = 8,
   parameter int          IDX_W       = 4,
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 12,
   parameter int          RD_W        = 32,
   parameter logic [11:0] REPORT_ADDR = 12'h1C0,
   parameter logic [11:0] STATUS_ADDR = 12'h02C,
   parameter int          EMPTY_BIT   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                page_start,
   input  logic                page_end,
   input  logic                pkt_valid,
   input  logic [IDX_W-1:0]    pkt_idx,
   input  logic [CNT_IN_W-1:0] pkt_err_cnt,
   input  logic                pkt_ok,
   input  logic                byte_valid,
   input  logic [DATA_W-1:0]   byte_data,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [RD_W-1:0]     rd_data
);
   if (IDX_W < 1 || DATA_W < 1) begin : g_bad_top
      $error("ecc_page_report: index and data widths must be positive");
   end

   rpt_word_t rpt_next;
   logic      empty_next;

   ecc_pkt_accum #(.CNT_IN_W(CNT_IN_W), .IDX_W(IDX_W)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .page_start (page_start),
      .pkt_valid  (pkt_valid),
      .pkt_idx    (pkt_idx),
      .pkt_err_cnt(pkt_err_cnt),
      .pkt_ok     (pkt_ok),
      .acc_next   (rpt_next)
   );

   ecc_empty_detect #(.DATA_W(DATA_W)) u_empty (
      .clk       (clk),
      .rst_n     (rst_n),
      .page_start(page_start),
      .byte_valid(byte_valid),
      .byte_data (byte_data),
      .empty_next(empty_next)
   );

   ecc_rpt_regs #(
      .ADDR_W     (ADDR_W),
      .RD_W       (RD_W),
      .REPORT_ADDR(REPORT_ADDR),
      .STATUS_ADDR(STATUS_ADDR),
      .EMPTY_BIT  (EMPTY_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .page_end  (page_end),
      .rpt_next  (rpt_next),
      .empty_next(empty_next),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );
endmodule

// File: tb/ecc_page_report_bench.sv
module ecc_page_report_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_start = 1'b0, page_end = 1'b0;
   logic        pkt_valid = 1'b0, pkt_ok = 1'b0;
   logic [3:0]  pkt_idx = '0;
   logic [7:0]  pkt_err_cnt = '0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam logic [11:0] A_RPT = 12'h1C0;
   localparam logic [11:0] A_STS = 12'h02C;

   always #5 clk = ~clk;

   ecc_page_report u_ecc_page_report (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_end(page_end),
      .pkt_valid(pkt_valid), .pkt_idx(pkt_idx), .pkt_err_cnt(pkt_err_cnt),
      .pkt_ok(pkt_ok), .byte_valid(byte_valid), .byte_data(byte_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   typedef struct packed {
      logic [7:0]  c0; logic k0;
      logic [7:0]  c1; logic k1;
      logic [7:0]  c2; logic k2;
      logic [7:0]  c3; logic k3;
      logic [15:0] exp;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'd5,   1'b1, 8'd3,  1'b1, 8'd7,  1'b1, 8'd2,   1'b1, 16'h8785},
      '{8'd0,   1'b0, 8'd0,  1'b1, 8'd0,  1'b1, 8'd0,   1'b1, 16'h8000},
      '{8'd10,  1'b1, 8'd20, 1'b1, 8'd4,  1'b0, 8'd1,   1'b1, 16'h148A},
      '{8'd200, 1'b1, 8'd70, 1'b1, 8'd63, 1'b1, 8'd9,   1'b1, 16'hBFBF},
      '{8'd63,  1'b0, 8'd64, 1'b0, 8'd0,  1'b0, 8'd255, 1'b0, 16'h3F3F},
      '{8'd1,   1'b1, 8'd6,  1'b1, 8'd6,  1'b1, 8'd6,   1'b1, 16'h8681}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      page_start = 1'b0; page_end = 1'b0; pkt_valid = 1'b0;
      byte_valid = 1'b0; rd_en = 1'b0;
   endtask

   task automatic pkt(input logic [3:0] idx, input logic [7:0] cnt, input logic ok);
      pkt_valid = 1'b1; pkt_idx = idx; pkt_err_cnt = cnt; pkt_ok = ok;
      tick();
   endtask

   task automatic put_byte(input logic [7:0] b);
      byte_valid = 1'b1; byte_data = b;
      tick();
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      rd_en = 1'b1; rd_addr = a;
      tick();
      v = rd_data;
   endtask

   task automatic pulse_start(); page_start = 1'b1; tick(); endtask
   task automatic pulse_end();   page_end = 1'b1;   tick(); endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();

      rd(A_RPT, v); check("R1 reset report", v, 32'h0000_8080);
      rd(A_STS, v); check("R1 reset status", v, 32'h0);

      for (int i = 0; i < 6; i++) begin
         pulse_start();
         pkt(4'd0, VECS[i].c0, VECS[i].k0);
         pkt(4'd1, VECS[i].c1, VECS[i].k1);
         pkt(4'd2, VECS[i].c2, VECS[i].k2);
         pkt(4'd3, VECS[i].c3, VECS[i].k3);
         put_byte(8'h00);
         pulse_end();
         rd(A_RPT, v);
         check($sformatf("R2 R3 R4 R5 vector %0d", i), v, {16'h0, VECS[i].exp});
         rd(A_STS, v); check("R8 non-empty page status", v, 32'h0);
      end

      // R7: mid-page read returns previous page, then same-cycle read and commit
      pulse_start();
      pkt(4'd0, 8'd2, 1'b1);
      rd(A_RPT, v); check("R7 mid-page read", v, 32'h0000_8681);
      page_end = 1'b1; rd_en = 1'b1; rd_addr = A_RPT;
      tick(); v = rd_data;
      check("R7 read during commit", v, 32'h0000_8681);
      rd(A_RPT, v); check("R7 read after commit", v, 32'h0000_8082);

      // R9: rd_data holds while rd_en is low; unmapped address reads 0
      tick(); tick();
      check("R9 hold", rd_data, 32'h0000_8082);
      rd(12'h1C4, v); check("R9 unmapped", v, 32'h0);

      // R6: page with no records
      pulse_start(); pulse_end();
      rd(A_RPT, v); check("R6 empty record page", v, 32'h0000_8080);
      rd(A_STS, v); check("R8 no bytes seen", v, 32'h0);

      // R8: all 0xFF page
      pulse_start();
      put_byte(8'hFF); put_byte(8'hFF); put_byte(8'hFF);
      pulse_end();
      rd(A_STS, v); check("R8 erased page", v, 32'h0001_0000);

      // R8: one non-FF byte among FF
      pulse_start();
      put_byte(8'hFF); put_byte(8'h7F); put_byte(8'hFF);
      pulse_end();
      rd(A_STS, v); check("R8 one bit flip", v, 32'h0);

      // R10: records on the strobe cycles
      page_start = 1'b1; pkt_valid = 1'b1; pkt_idx = 4'd0; pkt_err_cnt = 8'd9; pkt_ok = 1'b1;
      byte_valid = 1'b1; byte_data = 8'hFF;
      tick();
      pulse_end();
      rd(A_RPT, v); check("R10 record with page start", v, 32'h0000_8089);
      rd(A_STS, v); check("R10 byte with page start", v, 32'h0001_0000);

      pulse_start();
      pkt(4'd0, 8'd1, 1'b1);
      page_end = 1'b1; pkt_valid = 1'b1; pkt_idx = 4'd2; pkt_err_cnt = 8'd12; pkt_ok = 1'b0;
      tick();
      rd(A_RPT, v); check("R10 record with page end", v, 32'h0000_0C81);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule